// File: doc/BRIEF.md
# One-Time-Programmable Array Programming Port

This block is the access port that an external programmer drives when a one-time-programmable byte array is in programming mode. Three active-low controls are sampled on every rising clock edge: a chip select, a read enable and a program strobe. They sit alongside a 17-bit address bus and an 8-bit data input. A read returns the stored byte one cycle later. A program pulse merges the input byte into the addressed cell, and because the merge is an AND, a bit can go from 1 to 0 but never back.

The array is a register file whose depth is set by a parameter. Every cell comes out of reset erased to FFh. Bit 0 of cell 0 acts as a readback lock. Once a program operation clears it, which writing FEh to address 0 does, every read returns FFh. No electronic-signature or identification mode exists. Addresses at or above the configured depth read as erased, and program pulses to them are dropped.

Top module: `otp_prog_port`

## Requirements
- R1: While `rst` is high at a clock edge, every cell returns to FFh. After that edge `dout_en` is 0 and `dout` is 00h.
- R2: A read is requested when `ce_n`=0, `oe_n`=0 and `pgm_n`=1 are sampled at an edge. After that same edge, `dout_en` is 1 and `dout` holds the addressed cell's contents as of just before the edge.
- R3: When an edge samples anything other than the read combination, `dout_en` is 0 and `dout` is 00h after that edge.
- R4: A program operation happens when `pgm_n` is sampled 0 at an edge after being sampled 1 at the previous edge, while `ce_n`=0 and `oe_n`=1. It replaces the addressed cell with (old AND `din`), and a read issued on the next cycle returns the new value.
- R5: Ones written over zeros have no effect: no program operation ever sets a cleared bit back to 1.
- R6: A single low pulse on `pgm_n` writes at most once, however many cycles it lasts. A change to `din` or `ce_n` while the strobe stays low has no effect.
- R7: A falling program strobe is ignored when `ce_n`=1 or `oe_n`=0 at the edge where it is first sampled low.
- R8: Cells may be programmed in any order and one at a time. A program operation changes no cell other than the one addressed.
- R9: When bit 0 of cell 0 is 0, every read returns FFh whatever the stored contents. Programming FEh to address 0 sets this state.
- R10: An address at or above the array depth reads as FFh, and a program operation there changes no cell, including the cell its low address bits would alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset; erases the array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| pgm_n | input | 1 | Program strobe, active low, edge-detected |
| addr | input | 17 | Byte address |
| din | input | 8 | Program data (bits at 0 are cleared) |
| dout | output | 8 | Read data, 00h when not driven |
| dout_en | output | 1 | Read data valid; models the tri-state enable |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. A read sampled at edge k shows on `dout`/`dout_en` after edge k. A program operation sampled at edge k becomes visible through a read sampled at edge k+1, and therefore on the outputs after edge k+1. The driver task drives pins at the falling edge and tags each expected output with the index of the next rising edge. The monitor compares at the following falling edge only the item whose tag matches the current edge count. Every cycle produces an item, so idle and blocked cycles are checked as well as reads.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned OTP_ADDR_W = 17;
    localparam int unsigned OTP_DATA_W = 8;

    typedef logic [OTP_DATA_W-1:0] otp_byte_t;

    localparam otp_byte_t OTP_ERASED = '1;

    // Decoded meaning of one sampled control combination
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_PROG = 2'd2,
        OP_HOLD = 2'd3
    } otp_op_e;

    // Registered read response
    typedef struct packed {
        logic      valid;
        otp_byte_t data;
    } otp_resp_t;

    // Programming can only clear bits
    function automatic otp_byte_t otp_clear_merge(input otp_byte_t old_val,
                                                  input otp_byte_t new_val);
        return old_val & new_val;
    endfunction

    // Readback lock: bit 0 of cell 0 programmed to zero
    function automatic logic otp_locked(input otp_byte_t cell_zero);
        return ~cell_zero[0];
    endfunction

endpackage

// File: rtl/otp_strobe_decode.sv
module otp_strobe_decode
    import otp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    pgm_n,
    output otp_op_e op
);

    logic pgm_seen_hi_q;
    logic pgm_fall;

    // Strobe level from the previous edge; reset to inactive
    always_ff @(posedge clk) begin
        if (rst) begin
            pgm_seen_hi_q <= 1'b1;
        end else begin
            pgm_seen_hi_q <= pgm_n;
        end
    end

    assign pgm_fall = pgm_seen_hi_q & ~pgm_n;

    always_comb begin
        if (!ce_n && !oe_n && pgm_n) begin
            op = OP_READ;
        end else if (pgm_fall && !ce_n && oe_n) begin
            op = OP_PROG;
        end else if (!pgm_n) begin
            op = OP_HOLD;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned ADDR_W = OTP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  otp_byte_t         wdata,
    output otp_byte_t         rdata,
    output otp_byte_t         cell_zero
);

    localparam int unsigned IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    otp_byte_t        cells_q [DEPTH];
    logic             in_range;
    logic [IDX_W-1:0] idx;

    assign in_range = (addr < DEPTH_A);
    assign idx      = addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                cells_q[i] <= OTP_ERASED;
            end
        end else if (wr_en && in_range) begin
            cells_q[idx] <= otp_clear_merge(cells_q[idx], wdata);
        end
    end

    assign rdata     = in_range ? cells_q[idx] : OTP_ERASED;
    assign cell_zero = cells_q[0];

endmodule

// File: rtl/otp_read_gate.sv
module otp_read_gate
    import otp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_req,
    input  logic      locked,
    input  otp_byte_t cell_data,
    output otp_byte_t dout,
    output logic      dout_en
);

    otp_resp_t resp_d;
    otp_resp_t resp_q;

    always_comb begin
        resp_d.valid = rd_req;
        if (!rd_req) begin
            resp_d.data = '0;
        end else if (locked) begin
            resp_d.data = OTP_ERASED;
        end else begin
            resp_d.data = cell_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign dout    = resp_q.data;
    assign dout_en = resp_q.valid;

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
    import otp_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned ADDR_W = OTP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);

    otp_op_e   op;
    logic      wr_stb;
    logic      rd_req;
    logic      lock_q;
    otp_byte_t cell_rd;
    otp_byte_t cell_zero;

    otp_strobe_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .pgm_n (pgm_n),
        .op    (op)
    );

    assign wr_stb = (op == OP_PROG);
    assign rd_req = (op == OP_READ);

    otp_cell_array #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_arr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_stb),
        .addr      (addr),
        .wdata     (din),
        .rdata     (cell_rd),
        .cell_zero (cell_zero)
    );

    assign lock_q = otp_locked(cell_zero);

    otp_read_gate u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .locked    (lock_q),
        .cell_data (cell_rd),
        .dout      (dout),
        .dout_en   (dout_en)
    );

endmodule

// File: rtl/otp_prog_port_chk.sv
module otp_prog_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       oe_n,
    input logic       wr_stb,
    input logic       rd_req,
    input logic       lock_q,
    input logic [7:0] cell_zero,
    input logic [7:0] dout,
    input logic       dout_en
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!dout_en && dout == 8'h00));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dout_en == $past(rd_req)));

    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == 8'h00));

    assert_clear_only_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((cell_zero & ~$past(cell_zero)) == 8'h00));

    assert_single_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    assert_strobe_gated_R7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (!ce_n && oe_n));

    assert_lock_reads_ff_R9: assert property (@(posedge clk) disable iff (rst)
        (dout_en && $past(lock_q)) |-> (dout == 8'hFF));

endmodule

bind otp_prog_port otp_prog_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .wr_stb    (wr_stb),
    .rd_req    (rd_req),
    .lock_q    (lock_q),
    .cell_zero (cell_zero),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/sim_otp_prog_port.sv
`timescale 1ns/1ps
module sim_otp_prog_port;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        pgm_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    always #2.5 clk = ~clk;

    otp_prog_port #(.DEPTH(DEPTH), .ADDR_W(17)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct {
        int         due;
        logic       en;
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         cyc = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;
    logic [7:0] ref_mem [DEPTH];
    logic       ref_pq;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    // Monitor: each item is due after the edge it is tagged with
    always @(negedge clk) begin
        if (!rst && sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (dout_en !== e.en || dout !== e.data) begin
                n_bad++;
                $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                         e.tag, dout_en, dout, e.en, e.data);
            end
        end
    end

    function automatic logic [7:0] ref_read(input logic [16:0] a);
        if (!ref_mem[0][0]) return 8'hFF;
        if (a >= DEPTH) return 8'hFF;
        return ref_mem[a[3:0]];
    endfunction

    // Driver: one cycle of pins, expected output pushed from the model
    task automatic step(input logic ce, input logic oe, input logic pg,
                        input logic [16:0] a, input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        e.due  = cyc + 1;
        e.en   = (!ce && !oe && pg);
        e.data = e.en ? ref_read(a) : 8'h00;
        e.tag  = tag;
        sb.push_back(e);
        if (ref_pq && !pg && !ce && oe && a < DEPTH)
            ref_mem[a[3:0]] = ref_mem[a[3:0]] & d;
        ref_pq = pg;
        ce_n = ce; oe_n = oe; pgm_n = pg; addr = a; din = d;
    endtask

    task automatic prog(input logic [16:0] a, input logic [7:0] d, input string tag);
        step(1'b0, 1'b1, 1'b0, a, d, tag);
        step(1'b0, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [16:0] a, input string tag);
        step(1'b0, 1'b0, 1'b1, a, 8'h00, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        ref_pq = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        n_chk++;
        if (dout_en !== 1'b0 || dout !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: got en=%0b data=%02h, expected en=0 data=00", dout_en, dout);
        end
        step(1, 1, 1, 0, 0, "R3 idle");
        rd(3, "R1 erased cell");
        rd(15, "R1 erased last cell");
        // R4 program then read back
        prog(3, 8'hA5, "R4 program");
        rd(3, "R4 readback");
        // R5 ones cannot return
        prog(3, 8'hFF, "R5 write ones");
        rd(3, "R5 unchanged");
        prog(3, 8'h0F, "R5 further clear");
        rd(3, "R5 merged");
        // R6 long pulse, data changes while low
        step(0, 1, 0, 7, 8'hF0, "R6 pulse start");
        step(0, 1, 0, 7, 8'h0F, "R6 held");
        step(0, 1, 0, 7, 8'h00, "R6 held");
        step(0, 1, 1, 7, 8'h00, "R6 release");
        rd(7, "R6 single write");
        // R6 pulse begun deselected, then selected while low
        step(1, 1, 0, 10, 8'h00, "R6 start deselected");
        step(0, 1, 0, 10, 8'h00, "R6 selected while low");
        step(0, 1, 1, 10, 8'h00, "R6 release");
        rd(10, "R6 no write");
        // R7 blocked strobes
        step(1, 1, 0, 9, 8'h00, "R7 ce high");
        step(1, 1, 1, 9, 8'h00, "R7 release");
        rd(9, "R7 ce blocked");
        step(0, 0, 0, 9, 8'h00, "R7 oe low");
        step(0, 0, 1, 9, 8'h00, "R7 release");
        rd(9, "R7 oe blocked");
        step(1, 0, 1, 3, 8'h00, "R3 ce high read");
        step(0, 1, 1, 3, 8'h00, "R3 oe high");
        // R8 arbitrary order, neighbours untouched
        prog(12, 8'h3C, "R8 prog 12");
        prog(1, 8'h81, "R8 prog 1");
        prog(8, 8'h00, "R8 prog 8");
        rd(11, "R8 neighbour 11");
        rd(12, "R8 cell 12");
        rd(1, "R8 cell 1");
        rd(8, "R8 cell 8");
        rd(2, "R8 neighbour 2");
        rd(3, "R8 earlier cell");
        // R10 out of range
        prog(16, 8'h00, "R10 prog alias");
        prog(17'h1FFFF, 8'h00, "R10 prog top");
        rd(16, "R10 read 16");
        rd(17'h1FFFF, "R10 read top");
        rd(0, "R10 alias untouched");
        // R9 lock
        prog(0, 8'hFE, "R9 set lock");
        rd(3, "R9 locked 3");
        rd(12, "R9 locked 12");
        rd(8, "R9 locked 8");
        rd(0, "R9 locked 0");
        step(1, 1, 1, 0, 0, "R3 idle end");
        step(1, 1, 1, 0, 0, "R3 idle end");
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2: got %0d pending results, expected 0", sb.size());
        end
        finish_run();
    end

endmodule